// File: doc/BRIEF.md
# SPI-Accessed Shared Packet Buffer

This block holds one radio frame at a time in a 128-byte RAM that serves both directions. A host reaches it through a slave-only 4-wire SPI port (mode 0). It loads a frame for transmission there, and it reads back a frame that the radio side has deposited. The radio side has its own byte-write port and a completion strobe. The strobe records the frame length in a register outside the RAM and places the link-quality byte directly after the last frame byte.

Every SPI transaction opens with one control byte. It chooses buffer or register space, the direction, and single-byte or burst access, and for register space it carries the address. While that byte is shifted in, the block shifts out its interrupt status byte, so each access also polls status. A protect bit stops the radio side from overwriting the RAM while leaving host writes alone. A buffer read that goes past the received data raises an under-run flag.

All SPI pins are brought into the system clock through two-flop synchronizers and handled by oversampling. The SPI clock must therefore run well below the system clock; at least eight system clocks per SPI half period are assumed.

Top module: `shared_pkt_buffer`

## Requirements
- R1: After reset, MISO is not driven, irq is low, and the status, receive-length and control registers all read 0.
- R2: While the control byte is shifted in, MISO carries the status byte MSB first. Status bit 0 is frame-received and bit 1 is under-run.
- R3: Control byte: bit 7 = 1 selects the buffer and 0 the registers, and bit 6 = 1 means read. For register access, bits 5:0 give the start address. For buffer access, bit 5 = 0 is a burst from address 0. Bit 5 = 1 is single mode: the next byte is the address (bits 6:0) and one data byte follows. Any further bytes are ignored on write and read as 0x00.
- R4: Register 1 is the read-only receive length. It is loaded from rad_len on rad_done and changes at no other time, and host writes to it have no effect.
- R5: A radio write stores rad_data at rad_addr. On rad_done, rad_lqi is stored at address rad_len, right after the last frame byte.
- R6: Register 2 bit 0 is the protect bit. While it is set, radio data and the link-quality byte do not reach the RAM, but host writes do.
- R7: Burst accesses auto-increment the address by one per data byte, wrap modulo 128, and have no length limit.
- R8: spi_miso_oe is high only while the select is active. MOSI is sampled on rising SCLK and MISO changes on falling SCLK.
- R9: When a buffer read data byte whose address exceeds the receive length is fully clocked, status bit 1 is set.
- R10: Writing register 0 clears the status bits written as 1. irq is high whenever any status bit is set.
- R11: A burst write places the first byte (the transmit frame length) at address 0 and the following bytes at the next addresses, and a burst read returns them in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock from the host, idle low |
| spi_cs_n | input | 1 | SPI select, active low |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI data to the host |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad |
| rad_we | input | 1 | Radio-side byte write strobe |
| rad_addr | input | 7 | Radio-side write address |
| rad_data | input | 8 | Radio-side write data |
| rad_done | input | 1 | Received frame complete strobe |
| rad_len | input | 7 | Received frame length, valid with rad_done |
| rad_lqi | input | 8 | Link-quality byte, valid with rad_done |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
Assertions check on every cycle that MISO is released once the synchronized select goes high, and that bytes complete only on 8-bit boundaries. They also check that the receive length moves only on rad_done, that burst pointers step by one, and that the under-run flag rises only after a completed read byte. A pending host write must drain whenever the write port is free, and a protected frame must leave no link-quality write behind. Data content is shown only by the bench scenarios: readback order and wrap, the position of the link-quality byte, protect behaviour, single-mode byte skipping, write-one-to-clear, and the status value returned in each control byte.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 6;

  // control word bit positions
  localparam int CW_BUF    = 7;
  localparam int CW_RD     = 6;
  localparam int CW_SINGLE = 5;

  // register map
  localparam logic [REG_AW-1:0] RA_STATUS = 6'd0;
  localparam logic [REG_AW-1:0] RA_RXLEN  = 6'd1;
  localparam logic [REG_AW-1:0] RA_CTRL   = 6'd2;

  // status bits
  localparam int ST_FRAME = 0;
  localparam int ST_UNDER = 1;

  typedef enum logic [1:0] {
    XS_CMD  = 2'd0,
    XS_ADDR = 2'd1,
    XS_DATA = 2'd2,
    XS_SKIP = 2'd3
  } xs_t;
endpackage

// File: rtl/pbuf_sync.sv
module pbuf_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pbuf_ram.sv
module pbuf_ram #(
  parameter int DW = 8,
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pbuf_spi_phy.sv
module pbuf_spi_phy #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  input  logic [7:0] tx_byte,
  output logic       load_now,
  output logic       load_first,
  output logic       active,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso,
  output logic       miso_oe
);
  logic       sclk_s, cs_n_s, mosi_s, sclk_prev;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh, tx_sh;
  logic       start_evt, rise_evt, fall_evt;

  pbuf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_sclk, spi_cs_n, spi_mosi}),
    .q({sclk_s, cs_n_s, mosi_s})
  );

  always_comb begin
    start_evt  = !cs_n_s && !active;
    rise_evt   = active && !cs_n_s && sclk_s && !sclk_prev;
    fall_evt   = active && !cs_n_s && !sclk_s && sclk_prev;
    load_first = start_evt;
    load_now   = start_evt || (fall_evt && bit_cnt == 3'd0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      active    <= 1'b0;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      miso      <= 1'b0;
      miso_oe   <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      byte_done <= 1'b0;
      if (cs_n_s) begin
        active  <= 1'b0;
        bit_cnt <= '0;
        miso    <= 1'b0;
        miso_oe <= 1'b0;
      end else begin
        active <= 1'b1;
        if (load_now) begin
          miso    <= tx_byte[7];
          tx_sh   <= tx_byte[6:0];
          miso_oe <= 1'b1;
        end else if (fall_evt) begin
          miso  <= tx_sh[6];
          tx_sh <= {tx_sh[5:0], 1'b0};
        end
        if (rise_evt) begin
          rx_sh   <= {rx_sh[5:0], mosi_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_done <= 1'b1;
            rx_byte   <= {rx_sh, mosi_s};
          end
        end
      end
    end
  end

  assert_oe_release_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !miso_oe);

  assert_byte_frame_R8: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> (bit_cnt == 3'd0));
endmodule

// File: rtl/shared_pkt_buffer.sv
module shared_pkt_buffer
  import pbuf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  input  logic          rad_we,
  input  logic [AW-1:0] rad_addr,
  input  logic [7:0]    rad_data,
  input  logic          rad_done,
  input  logic [AW-1:0] rad_len,
  input  logic [7:0]    rad_lqi,
  output logic          irq
);
  // protocol state
  xs_t           xs;
  logic          is_buf, is_rd, is_single;
  logic [AW-1:0] ptr;
  logic [AW-1:0] rx_len;
  logic          protect;
  logic [1:0]    status;
  logic          rd_bad;
  // write port requests
  logic          hw_pend, lqi_pend;
  logic [AW-1:0] hw_addr, lqi_addr;
  logic [7:0]    hw_data, lqi_data;
  // phy handshake
  logic          load_now, load_first, phy_active, byte_done;
  logic [7:0]    rx_byte, tx_byte, reg_rd, ram_q;
  // ram write port
  logic          rad_grant, lqi_grant, host_grant, ram_we;
  logic [AW-1:0] ram_waddr;
  logic [7:0]    ram_wdata;
  // decoded events
  logic          data_byte, host_buf_wr, host_reg_wr, data_rd_phase;
  logic [1:0]    st_clr, st_set;

  pbuf_spi_phy #(.SYNC_STAGES(SYNC_STAGES)) u_phy (
    .clk(clk), .rst(rst),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .tx_byte(tx_byte), .load_now(load_now), .load_first(load_first),
    .active(phy_active), .byte_done(byte_done), .rx_byte(rx_byte),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  pbuf_ram #(.DW(BYTE_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ptr), .rdata(ram_q)
  );

  // register read mux and outgoing byte selection
  always_comb begin
    case (ptr[REG_AW-1:0])
      RA_STATUS: reg_rd = {6'b0, status};
      RA_RXLEN:  reg_rd = 8'(rx_len);
      RA_CTRL:   reg_rd = {7'b0, protect};
      default:   reg_rd = 8'h00;
    endcase
    data_rd_phase = (xs == XS_DATA) && is_rd;
    if (load_first)         tx_byte = {6'b0, status};
    else if (data_rd_phase) tx_byte = is_buf ? ram_q : reg_rd;
    else                    tx_byte = 8'h00;
  end

  // event decode
  always_comb begin
    data_byte   = byte_done && phy_active && (xs == XS_DATA);
    host_buf_wr = data_byte && !is_rd && is_buf;
    host_reg_wr = data_byte && !is_rd && !is_buf;
    st_clr = (host_reg_wr && ptr[REG_AW-1:0] == RA_STATUS) ? rx_byte[1:0] : 2'b00;
    st_set = '0;
    st_set[ST_FRAME] = rad_done;
    st_set[ST_UNDER] = data_byte && is_rd && is_buf && rd_bad;
  end

  // write port arbitration: radio data, then link-quality byte, then host
  always_comb begin
    rad_grant  = rad_we && !protect;
    lqi_grant  = !rad_we && lqi_pend;
    host_grant = !rad_we && !lqi_pend && hw_pend;
    ram_we     = rad_grant || lqi_grant || host_grant;
    if (rad_grant) begin
      ram_waddr = rad_addr;
      ram_wdata = rad_data;
    end else if (lqi_grant) begin
      ram_waddr = lqi_addr;
      ram_wdata = lqi_data;
    end else begin
      ram_waddr = hw_addr;
      ram_wdata = hw_data;
    end
  end

  // transaction sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      xs        <= XS_CMD;
      is_buf    <= 1'b0;
      is_rd     <= 1'b0;
      is_single <= 1'b0;
      ptr       <= '0;
    end else if (!phy_active) begin
      xs <= XS_CMD;
    end else if (byte_done) begin
      case (xs)
        XS_CMD: begin
          is_buf    <= rx_byte[CW_BUF];
          is_rd     <= rx_byte[CW_RD];
          is_single <= rx_byte[CW_BUF] && rx_byte[CW_SINGLE];
          if (rx_byte[CW_BUF]) begin
            if (rx_byte[CW_SINGLE]) begin
              xs <= XS_ADDR;
            end else begin
              ptr <= '0;
              xs  <= XS_DATA;
            end
          end else begin
            ptr <= AW'(rx_byte[REG_AW-1:0]);
            xs  <= XS_DATA;
          end
        end
        XS_ADDR: begin
          ptr <= rx_byte[AW-1:0];
          xs  <= XS_DATA;
        end
        XS_DATA: begin
          ptr <= ptr + 1'b1;
          if (is_single) xs <= XS_SKIP;
        end
        default: ;
      endcase
    end
  end

  // read bookkeeping for the under-run flag
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bad <= 1'b0;
    end else if (load_now) begin
      rd_bad <= !load_first && data_rd_phase && is_buf && (ptr > rx_len);
    end
  end

  // host buffer write request
  always_ff @(posedge clk) begin
    if (rst) begin
      hw_pend <= 1'b0;
      hw_addr <= '0;
      hw_data <= '0;
    end else if (host_buf_wr) begin
      hw_pend <= 1'b1;
      hw_addr <= ptr;
      hw_data <= rx_byte;
    end else if (host_grant) begin
      hw_pend <= 1'b0;
    end
  end

  // received frame completion
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_len   <= '0;
      lqi_pend <= 1'b0;
      lqi_addr <= '0;
      lqi_data <= '0;
    end else if (rad_done) begin
      rx_len <= rad_len;
      if (!protect) begin
        lqi_pend <= 1'b1;
        lqi_addr <= rad_len;
        lqi_data <= rad_lqi;
      end
    end else if (lqi_grant) begin
      lqi_pend <= 1'b0;
    end
  end

  // registers and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      protect <= 1'b0;
      status  <= '0;
      irq     <= 1'b0;
    end else begin
      if (host_reg_wr && ptr[REG_AW-1:0] == RA_CTRL) protect <= rx_byte[0];
      status <= (status & ~st_clr) | st_set;
      irq    <= |status;
    end
  end

  assert_len_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !rad_done |=> $stable(rx_len));

  assert_protect_no_lqi_R6: assert property (@(posedge clk) disable iff (rst)
    (protect && rad_done && !lqi_pend) |=> !lqi_pend);

  assert_host_drain_R6: assert property (@(posedge clk) disable iff (rst)
    (hw_pend && !rad_we && !lqi_pend && !byte_done) |=> !hw_pend);

  assert_burst_step_R7: assert property (@(posedge clk) disable iff (rst)
    (byte_done && phy_active && xs == XS_DATA && !is_single)
      |=> (ptr == AW'($past(ptr) + 1'b1)));

  assert_under_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(status[ST_UNDER]) |-> $past(byte_done && is_rd && is_buf));
endmodule

// File: tb/shared_pkt_buffer_test.sv
module shared_pkt_buffer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic rad_we = 1'b0, rad_done = 1'b0;
  logic [6:0] rad_addr = '0, rad_len = '0;
  logic [7:0] rad_data = '0, rad_lqi = '0;
  logic miso, miso_oe, irq;

  int n_chk = 0, n_fail = 0, idle_cnt = 0;
  bit finished = 0;

  logic [7:0] m_mem [128];
  bit         m_known [128];
  logic [6:0] m_len = '0;
  logic       m_prot = 1'b0;
  logic [1:0] m_stat = '0;

  always #4 clk = ~clk;

  shared_pkt_buffer uut (
    .clk(clk), .rst(rst),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe),
    .rad_we(rad_we), .rad_addr(rad_addr), .rad_data(rad_data),
    .rad_done(rad_done), .rad_len(rad_len), .rad_lqi(rad_lqi),
    .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int reg_model(input int a);
    case (a & 63)
      0: return int'(m_stat);
      1: return int'(m_len);
      2: return int'(m_prot);
      default: return 0;
    endcase
  endfunction

  // per-clock reference comparison while the bus is quiet
  always begin
    @(posedge clk);
    #1;
    if (rst || !cs_n || rad_we || rad_done) idle_cnt = 0;
    else idle_cnt++;
    if (idle_cnt >= 6 && !finished) begin
      chk("R8 MISO released when idle", int'(miso_oe), 0);
      chk("R10 irq follows status", int'(irq), int'(m_stat != 0));
    end
  end

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      mosi = tx[i];
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      rx[i] = miso;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic begin_xfer(input logic [7:0] cmd);
    logic [7:0] r;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R8 MISO driven while selected", int'(miso_oe), 1);
    spi_byte(cmd, r);
    chk("R2 status in control byte", int'(r), int'(m_stat));
  endtask

  task automatic end_xfer();
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed + i * 7) & 255);
  endfunction

  // R11: byte 0 carries the transmit length, the frame follows
  task automatic buf_burst_write(input int n, input int seed);
    logic [7:0] r, d;
    begin_xfer(8'h80);
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? 8'(n - 1) : pat(seed, i);
      spi_byte(d, r);
      m_mem[i % 128] = d;
      m_known[i % 128] = 1;
    end
    end_xfer();
  endtask

  task automatic buf_burst_read(input int n);
    logic [7:0] r;
    begin_xfer(8'hC0);
    for (int i = 0; i < n; i++) begin
      int a = i % 128;
      spi_byte(8'h00, r);
      if (m_known[a]) chk("R7/R11/R5 burst read data", int'(r), int'(m_mem[a]));
      if (7'(a) > m_len) m_stat[1] = 1'b1;
    end
    end_xfer();
  endtask

  task automatic buf_single_write(input logic [6:0] a, input logic [7:0] d, input bit extra);
    logic [7:0] r;
    begin_xfer(8'hA0);
    spi_byte({1'b0, a}, r);
    spi_byte(d, r);
    m_mem[a] = d;
    m_known[a] = 1;
    if (extra) spi_byte(8'hEE, r);
    end_xfer();
  endtask

  task automatic buf_single_read(input logic [6:0] a, input bit extra, input string tag);
    logic [7:0] r;
    begin_xfer(8'hE0);
    spi_byte({1'b0, a}, r);
    spi_byte(8'h00, r);
    if (m_known[a]) chk(tag, int'(r), int'(m_mem[a]));
    if (a > m_len) m_stat[1] = 1'b1;
    if (extra) begin
      spi_byte(8'h00, r);
      chk("R3 byte after single read is zero", int'(r), 0);
    end
    end_xfer();
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] r;
    begin_xfer({2'b00, a});
    spi_byte(d, r);
    if (a == 6'd0) m_stat = m_stat & ~d[1:0];
    if (a == 6'd2) m_prot = d[0];
    end_xfer();
  endtask

  task automatic reg_read(input logic [5:0] a, input int n, input string tag);
    logic [7:0] r;
    begin_xfer({2'b01, a});
    for (int i = 0; i < n; i++) begin
      spi_byte(8'h00, r);
      chk(tag, int'(r), reg_model(int'(a) + i));
    end
    end_xfer();
  endtask

  task automatic radio_frame(input int len, input logic [7:0] lqi, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rad_we = 1'b1;
      rad_addr = 7'(i);
      rad_data = pat(seed, i);
      if (!m_prot) begin
        m_mem[i] = pat(seed, i);
        m_known[i] = 1;
      end
    end
    @(negedge clk);
    rad_we = 1'b0;
    rad_done = 1'b1;
    rad_len = 7'(len);
    rad_lqi = lqi;
    @(negedge clk);
    rad_done = 1'b0;
    if (!m_prot) begin
      m_mem[len] = lqi;
      m_known[len] = 1;
    end
    m_len = 7'(len);
    m_stat[0] = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) m_known[i] = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 MISO not driven after reset", int'(miso_oe), 0);
    chk("R1 irq low after reset", int'(irq), 0);
    reg_read(6'd0, 3, "R1 registers zero after reset");

    // transmit frame load and readback; reads beyond length 0 flag under-run
    buf_burst_write(6, 8'h30);
    buf_burst_read(6);
    reg_write(6'd0, 8'h03);

    // received frame with link-quality byte after the last byte
    radio_frame(10, 8'h5A, 8'h90);
    buf_burst_read(11);
    reg_read(6'd1, 1, "R4 receive length register");

    // under-run on the byte past the link-quality byte
    buf_burst_read(12);
    chk("R9 under-run bit set", int'(m_stat[1]), 1);
    reg_read(6'd0, 1, "R9 status shows under-run");

    // write-one-to-clear of single bits
    reg_write(6'd0, 8'h01);
    reg_read(6'd0, 1, "R10 only frame bit cleared");
    reg_write(6'd0, 8'h02);

    // protect blocks radio writes, host writes still land
    reg_write(6'd2, 8'h01);
    radio_frame(5, 8'h11, 8'h40);
    buf_single_read(7'd3, 0, "R6 frame byte kept under protect");
    buf_single_read(7'd5, 0, "R6 no link-quality write under protect");
    buf_single_write(7'd3, 8'h77, 0);
    buf_single_read(7'd3, 0, "R6 host write accepted under protect");
    reg_read(6'd0, 3, "R4/R6 registers after protected frame");

    // receive length is read-only
    reg_write(6'd1, 8'h33);
    reg_read(6'd1, 1, "R4 length ignores host write");

    // single mode: extra bytes ignored
    buf_single_write(7'd4, 8'h5C, 1);
    buf_single_read(7'd5, 1, "R3 extra single-write byte ignored");
    buf_single_read(7'd4, 0, "R3 single write landed");

    // burst wrap beyond 128 bytes
    reg_write(6'd2, 8'h00);
    reg_write(6'd0, 8'h03);
    buf_burst_write(130, 8'h11);
    buf_burst_read(130);
    reg_write(6'd0, 8'h03);

    // new frame after unprotect: link-quality byte placed at the length
    radio_frame(3, 8'hA7, 8'h21);
    buf_burst_read(4);
    chk("R5 model holds link-quality at length", int'(m_mem[3]), 8'hA7);
    reg_read(6'd0, 3, "R10 registers before final clear");
    reg_write(6'd0, 8'h03);
    repeat (20) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule